// File: doc/BRIEF.md
# SPI Master Command Sequencer

This block runs one SPI master transaction per command. A command is captured in a single cycle from a set of parallel inputs. It carries:

- an operation code (write or read);
- a count of address bytes (0 to 3) taken from a split 16-bit high / 8-bit low address pair;
- a data byte count;
- a repeat count;
- a flag that keeps the chip select asserted after the command.

The sequencer asserts the active-low chip select, shifts out the address bytes, and then moves the data bytes. On a write, data bytes come from an outgoing byte FIFO. On a read, received bytes go into an incoming byte FIFO. It then either releases the bus or runs the command again.

The serial clock is the system clock divided by twice a parameter. Clock polarity, clock phase and the data bit order are configuration inputs. An optional flow-control input, with selectable stalling level, holds back the start of each transaction. Status outputs report the command in progress, the data bytes still to move, and a state code. Two one-cycle pulses mark completion and an illegal command. FIFO storage itself lies outside the block.

Top module: `spi_cmd_seq`

## Requirements
- R1: With `cmd_wr` high in idle, an op code of 1 (write) or 2 (read) is accepted. From the next cycle `stat_state` reads 2 and `stat_cmd` shows the op code.
- R2: Address bytes are sent before any data, most significant bit first in every mode. For a count of 3 the order is `offset_hi[15:8]`, `offset_hi[7:0]`, `offset_lo`. For 2 it is `offset_hi[7:0]`, `offset_lo`. For 1 it is `offset_lo` alone.
- R3: Data bytes go on the wire MSB first when `cfg_lsb_first` is 0 and LSB first when it is 1. A write sends the bytes popped from `tx_data`. A read sends 0x00 and pushes each received byte, in the same bit order, on `rx_data`.
- R4: `cmd_size` counts data bytes only. `stat_remain` counts down by one per data byte. A size of 0 sends the address bytes alone.
- R5: A repeat count N runs the whole transaction N+1 times. `cs_n` goes high between passes. `evt_done` pulses exactly once, after the last pass.
- R6: `cmd_wr` while a command is in progress makes `evt_illegal` pulse in the next cycle. The new command is ignored and the running transfer is unchanged.
- R7: `stat_state` encodes 4 = idle, 2 = active, 6 = waiting on FIFO data or space, and 1 = error. The error code appears in the cycle after an op code other than 1 or 2 is written; such a command starts no transfer.
- R8: With `cs_n` high, `sclk` sits at `cfg_cpol`. With `cfg_cpha` 0 both sides sample on the leading edge; with `cfg_cpha` 1 they sample on the trailing edge.
- R9: With `flow_en` 1, `cs_n` does not fall while `flow_in` equals `flow_stall_hi`. A high input stalls when `flow_stall_hi` is 1; a low input stalls when it is 0.
- R10: With `cmd_cont` 1, `cs_n` stays low after completion, so a following command extends the same selection.
- R11: A write with `tx_empty` high, or a read with `rx_full` high, holds before the next data byte with `stat_state` = 6. No serial clock moves until the FIFO allows it.
- R12: Successive `sclk` edges within a byte are exactly `HALF_DIV` system clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_op | input | 2 | Op code: 1 write, 2 read |
| cmd_offcnt | input | 2 | Number of address bytes, 0 to 3 |
| cmd_size | input | SIZE_W | Data byte count |
| cmd_repeat | input | RPT_W | Extra passes after the first |
| cmd_cont | input | 1 | Keep chip select low after completion |
| offset_hi | input | 16 | Upper address bytes |
| offset_lo | input | 8 | Lowest address byte |
| cfg_cpol | input | 1 | Idle clock level |
| cfg_cpha | input | 1 | Sample on trailing edge when 1 |
| cfg_lsb_first | input | 1 | Data bit order, LSB first when 1 |
| flow_en | input | 1 | Enable start gating by `flow_in` |
| flow_stall_hi | input | 1 | Level of `flow_in` that stalls |
| flow_in | input | 1 | External ready signal |
| tx_data | input | 8 | Head byte of the outgoing FIFO |
| tx_empty | input | 1 | Outgoing FIFO empty |
| tx_pop | output | 1 | Consume the head byte |
| rx_full | input | 1 | Incoming FIFO full |
| rx_data | output | 8 | Received data byte |
| rx_push | output | 1 | Write `rx_data` into the incoming FIFO |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data in |
| stat_cmd | output | 2 | Op code in progress, 0 when idle |
| stat_state | output | 3 | State code |
| stat_remain | output | SIZE_W | Data bytes still to move in this pass |
| evt_done | output | 1 | One-cycle completion pulse |
| evt_illegal | output | 1 | One-cycle illegal-command pulse |

## Verification
The status outputs change in the cycle after the accepting edge, and `evt_illegal` rises in the cycle after the offending strobe. The bench drives each strobe at a falling clock edge and reads these results at the next falling edge. Serial bytes are rebuilt from the wire at the sampling edge chosen by polarity and phase. Because the byte timing depends on the divider, completion is awaited through `evt_done` and the stream is compared afterwards. The wait code and the frozen remaining count are polled once the stall has had time to arise. Edge spacing, chip-select falls and pulse counts are gathered continuously at falling edges and compared once the command ends.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_READ  = 2'd2;

  localparam logic [2:0] CODE_ERR    = 3'd1;
  localparam logic [2:0] CODE_ACTIVE = 3'd2;
  localparam logic [2:0] CODE_IDLE   = 3'd4;
  localparam logic [2:0] CODE_WAIT   = 3'd6;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_GATE,
    SQ_LOAD,
    SQ_XFER,
    SQ_NEXT
  } sq_state_t;

  // mirror a byte for LSB-first data
  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  // address byte for the number of address bytes still to send
  function automatic logic [7:0] pick_offset(input logic [1:0] left,
                                             input logic [15:0] hi,
                                             input logic [7:0] lo);
    case (left)
      2'd3:    return hi[15:8];
      2'd2:    return hi[7:0];
      default: return lo;
    endcase
  endfunction

  function automatic logic flow_blocked(input logic en, input logic stall_hi,
                                        input logic lvl);
    return en && (lvl == stall_hi);
  endfunction

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  logic       cpha,
  input  logic [7:0] wire_byte,
  input  logic       miso,
  output logic       busy,
  output logic       sclk_raw,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);
  logic [3:0] k;
  logic [7:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      k        <= '0;
      sclk_raw <= 1'b0;
      sh       <= '0;
      rx_byte  <= '0;
      mosi     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy     <= 1'b1;
        k        <= '0;
        sclk_raw <= 1'b0;
        if (!cpha) begin
          mosi <= wire_byte[7];
          sh   <= {wire_byte[6:0], 1'b0};
        end else begin
          sh <= wire_byte;
        end
      end else if (busy && tick) begin
        sclk_raw <= ~sclk_raw;
        k        <= k + 4'd1;
        // even k is a leading edge, odd k a trailing edge
        if (k[0] == cpha) begin
          rx_byte <= {rx_byte[6:0], miso};
        end else begin
          mosi <= sh[7];
          sh   <= {sh[6:0], 1'b0};
        end
        if (k == 4'd15) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_seq_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int SIZE_W   = 8,
  parameter int RPT_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [1:0]        cmd_op,
  input  logic [1:0]        cmd_offcnt,
  input  logic [SIZE_W-1:0] cmd_size,
  input  logic [RPT_W-1:0]  cmd_repeat,
  input  logic              cmd_cont,
  input  logic [15:0]       offset_hi,
  input  logic [7:0]        offset_lo,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic              flow_en,
  input  logic              flow_stall_hi,
  input  logic              flow_in,
  input  logic [7:0]        tx_data,
  input  logic              tx_empty,
  output logic              tx_pop,
  input  logic              rx_full,
  output logic [7:0]        rx_data,
  output logic              rx_push,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  input  logic              miso,
  output logic [1:0]        stat_cmd,
  output logic [2:0]        stat_state,
  output logic [SIZE_W-1:0] stat_remain,
  output logic              evt_done,
  output logic              evt_illegal
);
  sq_state_t         st;
  logic [1:0]        op_q, offcnt_q, off_left;
  logic [SIZE_W-1:0] size_q, remain;
  logic [RPT_W-1:0]  rpt_left;
  logic              cont_q, cs_act, err_q, done_q, ill_q, in_data;
  logic [15:0]       hi_q;
  logic [7:0]        lo_q;

  // named internal events
  logic       eng_tick, eng_busy, eng_done, eng_raw, eng_start;
  logic       off_pending, fifo_block, data_ready, pass_over, op_valid;
  logic [7:0] eng_byte, eng_rx, data_byte;

  assign op_valid    = (cmd_op == OP_WRITE) || (cmd_op == OP_READ);
  assign off_pending = (off_left != 2'd0);
  assign fifo_block  = (op_q == OP_WRITE) ? tx_empty : rx_full;
  assign pass_over   = !off_pending && (remain == '0);
  assign data_ready  = !off_pending && (remain != '0) && !fifo_block;
  assign eng_start   = (st == SQ_LOAD) && (off_pending || data_ready);

  assign data_byte = (op_q == OP_WRITE)
                   ? (cfg_lsb_first ? rev8(tx_data) : tx_data) : 8'h00;
  assign eng_byte  = off_pending ? pick_offset(off_left, hi_q, lo_q) : data_byte;

  assign tx_pop  = (st == SQ_LOAD) && data_ready && (op_q == OP_WRITE);
  assign rx_push = (st == SQ_XFER) && eng_done && in_data && (op_q == OP_READ);
  assign rx_data = cfg_lsb_first ? rev8(eng_rx) : eng_rx;

  assign sclk        = eng_raw ^ cfg_cpol;
  assign cs_n        = ~cs_act;
  assign evt_done    = done_q;
  assign evt_illegal = ill_q;
  assign stat_remain = remain;
  assign stat_cmd    = (st == SQ_IDLE) ? 2'd0 : op_q;

  always_comb begin
    if (st == SQ_IDLE)
      stat_state = err_q ? CODE_ERR : CODE_IDLE;
    else if (st == SQ_LOAD && !off_pending && remain != '0 && fifo_block)
      stat_state = CODE_WAIT;
    else
      stat_state = CODE_ACTIVE;
  end

  spi_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(eng_busy), .tick(eng_tick)
  );

  spi_byte_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(eng_tick), .start(eng_start),
    .cpha(cfg_cpha), .wire_byte(eng_byte), .miso(miso), .busy(eng_busy),
    .sclk_raw(eng_raw), .mosi(mosi), .done(eng_done), .rx_byte(eng_rx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      op_q     <= '0;
      offcnt_q <= '0;
      off_left <= '0;
      size_q   <= '0;
      remain   <= '0;
      rpt_left <= '0;
      cont_q   <= 1'b0;
      cs_act   <= 1'b0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
      ill_q    <= 1'b0;
      in_data  <= 1'b0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else begin
      done_q <= 1'b0;
      ill_q  <= cmd_wr && (st != SQ_IDLE);
      case (st)
        SQ_IDLE: if (cmd_wr) begin
          if (op_valid) begin
            op_q     <= cmd_op;
            offcnt_q <= cmd_offcnt;
            size_q   <= cmd_size;
            remain   <= cmd_size;
            rpt_left <= cmd_repeat;
            cont_q   <= cmd_cont;
            hi_q     <= offset_hi;
            lo_q     <= offset_lo;
            err_q    <= 1'b0;
            st       <= SQ_GATE;
          end else begin
            err_q <= 1'b1;
          end
        end
        SQ_GATE: if (!flow_blocked(flow_en, flow_stall_hi, flow_in)) begin
          cs_act   <= 1'b1;
          off_left <= offcnt_q;
          remain   <= size_q;
          st       <= SQ_LOAD;
        end
        SQ_LOAD: begin
          if (eng_start) begin
            in_data <= !off_pending;
            st      <= SQ_XFER;
          end else if (pass_over) begin
            st <= SQ_NEXT;
          end
        end
        SQ_XFER: if (eng_done) begin
          if (in_data) remain   <= remain - 1'b1;
          else         off_left <= off_left - 2'd1;
          st <= SQ_LOAD;
        end
        SQ_NEXT: begin
          if (rpt_left != '0) begin
            rpt_left <= rpt_left - 1'b1;
            cs_act   <= 1'b0;
            st       <= SQ_GATE;
          end else begin
            done_q <= 1'b1;
            cs_act <= cont_q;
            st     <= SQ_IDLE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_seq_chk.sv
module spi_cmd_seq_chk #(
  parameter int SIZE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_wr,
  input logic              cs_n,
  input logic              sclk,
  input logic              cfg_cpol,
  input logic              evt_done,
  input logic              evt_illegal,
  input logic [2:0]        stat_state,
  input logic [SIZE_W-1:0] stat_remain,
  input logic              tx_pop,
  input logic              tx_empty,
  input logic              rx_push,
  input logic              flow_en,
  input logic              flow_stall_hi,
  input logic              flow_in
);
  p_illegal_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && (stat_state == 3'd2 || stat_state == 3'd6)) |=> evt_illegal);

  p_done_to_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> (stat_state == 3'd4));

  p_flow_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(!(flow_en && (flow_in == flow_stall_hi))));

  p_sclk_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sclk == cfg_cpol));

  p_no_pop_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);

  p_push_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !cs_n);

  p_wait_holds_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_state == 3'd6) |=> (stat_remain == $past(stat_remain)));
endmodule

bind spi_cmd_seq spi_cmd_seq_chk #(.SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cs_n(cs_n), .sclk(sclk),
  .cfg_cpol(cfg_cpol), .evt_done(evt_done), .evt_illegal(evt_illegal),
  .stat_state(stat_state), .stat_remain(stat_remain), .tx_pop(tx_pop),
  .tx_empty(tx_empty), .rx_push(rx_push), .flow_en(flow_en),
  .flow_stall_hi(flow_stall_hi), .flow_in(flow_in)
);

// File: tb/spi_cmd_seq_bench.sv
`timescale 1ns/1ps
module spi_cmd_seq_bench;
  localparam int HD = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 0, cmd_cont = 0;
  logic [1:0] cmd_op = 0, cmd_offcnt = 0;
  logic [7:0] cmd_size = 0;
  logic [3:0] cmd_repeat = 0;
  logic [15:0] offset_hi = 0;
  logic [7:0] offset_lo = 0;
  logic cfg_cpol = 0, cfg_cpha = 0, cfg_lsb_first = 0;
  logic flow_en = 0, flow_stall_hi = 0, flow_in = 0;
  logic [7:0] tx_data;
  logic tx_empty, tx_pop, rx_full = 0, rx_push, sclk, mosi, cs_n, miso = 0;
  logic [7:0] rx_data;
  logic [1:0] stat_cmd;
  logic [2:0] stat_state;
  logic [7:0] stat_remain;
  logic evt_done, evt_illegal;

  always #2.5 clk = ~clk;

  spi_cmd_seq #(.HALF_DIV(HD)) u_spi_cmd_seq (.*);

  int checks = 0, errs = 0;
  logic [7:0] tx_mem [256];
  int tx_rd = 0, tx_avail = 0;
  logic [7:0] rx_log [256];
  int rx_n = 0;
  logic [7:0] mlog [512];
  int bc = 0, cyc = 0, last_edge = 0, min_gap = 1000;
  int csf_cnt = 0, done_cnt = 0, ill_cnt = 0;
  logic prev_sclk = 0, prev_cs = 1;
  logic [7:0] cur = 0;
  logic [7:0] exp_m [512];
  logic [7:0] exp_r [256];
  int exp_n, exp_rn, exp_base, rx_base, d0;

  assign tx_empty = (tx_rd >= tx_avail);
  assign tx_data  = tx_mem[tx_rd % 256];

  function automatic logic [7:0] brev(input logic [7:0] b);
    logic [7:0] r = 0;
    for (int i = 0; i < 8; i++) r = {r[6:0], b[i]};
    return r;
  endfunction

  function automatic logic [7:0] resp(input int n);
    return 8'hA5 ^ 8'(n * 29);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // FIFO models
  always @(posedge clk) begin
    if (tx_pop) tx_rd <= tx_rd + 1;
    if (rx_push) begin
      rx_log[rx_n % 256] <= rx_data;
      rx_n <= rx_n + 1;
    end
  end

  // serial slave and event monitor
  always @(negedge clk) begin
    cyc++;
    if (prev_cs && !cs_n) csf_cnt++;
    if (evt_done) done_cnt++;
    if (evt_illegal) ill_cnt++;
    if (!cs_n && sclk != prev_sclk) begin
      if (cyc - last_edge < min_gap) min_gap = cyc - last_edge;
      last_edge = cyc;
      if ((sclk != cfg_cpol) != cfg_cpha) begin
        cur = {cur[6:0], mosi};
        bc++;
        if (bc % 8 == 0) mlog[(bc / 8 - 1) % 512] = cur;
      end
    end
    prev_sclk = sclk;
    prev_cs   = cs_n;
    miso = resp(bc / 8)[7 - (bc % 8)];
  end

  task automatic issue(input logic [1:0] op, input logic [1:0] oc, input int size,
                       input int rep, input bit cont, input logic [15:0] hi,
                       input logic [7:0] lo);
    int k = tx_rd;
    exp_base = bc / 8; rx_base = rx_n; exp_n = 0; exp_rn = 0;
    for (int r = 0; r <= rep; r++) begin
      for (int o = oc; o >= 1; o--) begin
        exp_m[exp_n % 512] = (o == 3) ? hi[15:8] : (o == 2) ? hi[7:0] : lo;
        exp_n++;
      end
      for (int d = 0; d < size; d++) begin
        if (op == 2'd1) begin
          exp_m[exp_n % 512] = cfg_lsb_first ? brev(tx_mem[k % 256]) : tx_mem[k % 256];
          k++;
        end else begin
          exp_m[exp_n % 512] = 8'h00;
          exp_r[exp_rn % 256] = cfg_lsb_first ? brev(resp(exp_base + exp_n))
                                              : resp(exp_base + exp_n);
          exp_rn++;
        end
        exp_n++;
      end
    end
    if (op == 2'd1) tx_avail = k;
    d0 = done_cnt;
    cmd_op = op; cmd_offcnt = oc; cmd_size = 8'(size); cmd_repeat = 4'(rep);
    cmd_cont = cont; offset_hi = hi; offset_lo = lo; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    check(stat_state == 3'd2, "R1 active code after accept", stat_state, 2);
    check(stat_cmd == op, "R1 current op", stat_cmd, op);
  endtask

  task automatic finish_cmd(input string tag);
    int t = 0;
    int bad = 0, first = -1;
    while (done_cnt == d0 && t < 30000) begin @(negedge clk); t++; end
    check(done_cnt > d0, {tag, " R5 completion seen"}, done_cnt, d0 + 1);
    repeat (3) @(negedge clk);
    check(done_cnt == d0 + 1, {tag, " R5 single done pulse"}, done_cnt, d0 + 1);
    check(stat_state == 3'd4, {tag, " R7 idle code"}, stat_state, 4);
    check(bc == (exp_base + exp_n) * 8, {tag, " R4 wire bit count"}, bc, (exp_base + exp_n) * 8);
    for (int i = 0; i < exp_n; i++)
      if (mlog[(exp_base + i) % 512] != exp_m[i % 512]) begin
        bad++; if (first < 0) first = i;
      end
    if (first < 0) first = 0;
    check(bad == 0, {tag, " R2 R3 mosi stream"}, mlog[(exp_base + first) % 512], exp_m[first % 512]);
    check(rx_n - rx_base == exp_rn, {tag, " R3 rx byte count"}, rx_n - rx_base, exp_rn);
    bad = 0; first = -1;
    for (int i = 0; i < exp_rn; i++)
      if (rx_log[(rx_base + i) % 256] != exp_r[i % 256]) begin
        bad++; if (first < 0) first = i;
      end
    if (first < 0) first = 0;
    check(bad == 0, {tag, " R3 rx data"}, rx_log[(rx_base + first) % 256], exp_r[first % 256]);
  endtask

  task automatic reset_slave();
    bc = 0; cur = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int cs0, t;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) tx_mem[i] = 8'($urandom);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 R8 reset state
    check(cs_n == 1'b1, "R8 cs_n high after reset", cs_n, 1);
    check(sclk == 1'b0, "R8 sclk idle after reset", sclk, 0);
    check(stat_state == 3'd4, "R7 idle code after reset", stat_state, 4);
    check(!evt_done && !evt_illegal, "R5 R6 no events after reset", evt_done, 0);

    // directed write, three address bytes, MSB first
    reset_slave();
    issue(2'd1, 2'd3, 2, 0, 0, 16'hC3A1, 8'h5E);
    finish_cmd("wr3");

    // R6 illegal command during transfer
    reset_slave();
    issue(2'd1, 2'd2, 2, 0, 0, 16'h1234, 8'h9A);
    repeat (10) @(negedge clk);
    cmd_op = 2'd2; cmd_size = 8'd9; offset_lo = 8'hFF; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    check(evt_illegal == 1'b1, "R6 illegal pulse next cycle", evt_illegal, 1);
    check(stat_cmd == 2'd1, "R6 running op unchanged", stat_cmd, 1);
    finish_cmd("ill");

    // R1 R7 invalid op code
    cs0 = csf_cnt; d0 = done_cnt;
    cmd_op = 2'd3; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    check(stat_state == 3'd1, "R7 error code for op 3", stat_state, 1);
    repeat (40) @(negedge clk);
    check(csf_cnt == cs0 && cs_n, "R1 op 3 starts no transfer", csf_cnt - cs0, 0);
    check(done_cnt == d0, "R1 op 3 no completion", done_cnt - d0, 0);

    // R5 repeat on a read, mode 3 timing
    cfg_cpol = 1; cfg_cpha = 1;
    @(negedge clk);
    reset_slave(); cs0 = csf_cnt;
    issue(2'd2, 2'd1, 2, 2, 0, 16'h0, 8'h47);
    finish_cmd("rpt");
    check(csf_cnt - cs0 == 3, "R5 three selections for repeat 2", csf_cnt - cs0, 3);
    check(sclk == 1'b1, "R8 sclk idles high with cpol 1", sclk, 1);

    // R4 size zero sends address only
    cfg_cpol = 0; cfg_cpha = 1;
    @(negedge clk);
    reset_slave();
    issue(2'd2, 2'd2, 0, 0, 0, 16'hBEEF, 8'h11);
    finish_cmd("sz0");

    // R9 flow control, high stalls
    cfg_cpha = 0; flow_en = 1; flow_stall_hi = 1; flow_in = 1;
    @(negedge clk);
    reset_slave();
    issue(2'd1, 2'd1, 1, 0, 0, 16'h0, 8'h3C);
    repeat (60) @(negedge clk);
    check(cs_n == 1'b1, "R9 cs_n held while stalled", cs_n, 1);
    check(bc == 0, "R9 no bits while stalled", bc, 0);
    flow_in = 0;
    finish_cmd("flowhi");
    // low stalls: a high input lets it run
    flow_stall_hi = 0; flow_in = 1;
    issue(2'd2, 2'd1, 1, 0, 0, 16'h0, 8'h77);
    finish_cmd("flowlo");
    flow_en = 0;

    // R11 write waits on empty outgoing FIFO
    reset_slave();
    cs0 = 0;
    issue(2'd1, 2'd1, 3, 0, 0, 16'h0, 8'hA0);
    cs0 = tx_avail; tx_avail = tx_rd + 1;
    t = 0;
    while (stat_state != 3'd6 && t < 2000) begin @(negedge clk); t++; end
    check(stat_state == 3'd6, "R11 wait code on empty tx", stat_state, 6);
    check(stat_remain == 8'd2, "R4 remaining while waiting", stat_remain, 2);
    repeat (20) @(negedge clk);
    check(bc == 16 && stat_state == 3'd6, "R11 no clocks while waiting", bc, 16);
    tx_avail = cs0;
    finish_cmd("txwait");

    // R11 read waits on full incoming FIFO
    reset_slave();
    rx_full = 1;
    issue(2'd2, 2'd0, 2, 0, 0, 16'h0, 8'h0);
    repeat (5) @(negedge clk);
    check(stat_state == 3'd6, "R11 wait code on full rx", stat_state, 6);
    check(stat_remain == 8'd2 && bc == 0, "R4 R11 full rx holds count", stat_remain, 2);
    rx_full = 0;
    finish_cmd("rxwait");

    // R10 continue keeps selection, LSB-first data
    cfg_cpol = 1; cfg_cpha = 1; cfg_lsb_first = 1;
    @(negedge clk);
    reset_slave(); cs0 = csf_cnt;
    issue(2'd1, 2'd2, 1, 0, 1, 16'h80F1, 8'h2D);
    finish_cmd("cont1");
    repeat (5) @(negedge clk);
    check(cs_n == 1'b0, "R10 cs_n stays low after continue", cs_n, 0);
    issue(2'd2, 2'd1, 2, 0, 0, 16'h0, 8'h6B);
    finish_cmd("cont2");
    check(cs_n == 1'b1, "R10 cs_n released after final", cs_n, 1);
    check(csf_cnt - cs0 == 1, "R10 single selection", csf_cnt - cs0, 1);

    // random transactions
    for (int n = 0; n < 14; n++) begin
      cfg_cpol = 1'($urandom); cfg_cpha = 1'($urandom); cfg_lsb_first = 1'($urandom);
      @(negedge clk);
      reset_slave();
      issue(2'd1 + 2'($urandom % 2), 2'($urandom % 4), int'($urandom % 6),
            int'($urandom % 3), 0, 16'($urandom), 8'($urandom));
      finish_cmd($sformatf("rnd%0d", n));
    end

    check(min_gap == HD, "R12 half period in clocks", min_gap, HD);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule